// File: doc/BRIEF.md
# Quad Strobed Fixed-Delay Pulse Timer

Four one-shot timer channels run from one clock and share a small set of common controls. Each channel has its own set line and its own pulse output. When a channel sees a valid start event, its output goes high. The output then stays high for exactly `PULSE_LEN` clock periods, which is 100 by default, and clears by itself. The delay is counted by a shift-register feedback sequence cut to exactly `PULSE_LEN` states, not by a binary counter.

A start event needs two things in the same cycle. The first is the channel's set line being high. The second is a qualifying edge, which is one of these:
- a rising edge on the positive strobe;
- a falling edge on the negative strobe;
- a rising edge on the common arm line.

In a second mode the common arm line is held high, and a rising edge on a channel's own set line starts that channel alone.

A common input-disable blocks all new start events. A common inhibit aborts every cycle in progress, holds all outputs low and blocks new starts. All control inputs pass through a two-flop synchronizer, and edges are found on the synchronized copies.

Top module: `quad_pulse_timer`

## Requirements
- R1: During and directly after the synchronous active-low reset, every bit of `pulse_out` is 0.
- R2: A started pulse stays high for exactly `PULSE_LEN` (100) clock periods when no inhibit occurs, then returns to 0.
- R3: A 0-to-1 change on `strobe_rise` while the channel's `set_in` bit is 1 starts that channel. The output is first seen high after the third rising clock edge that follows the input change.
- R4: A 1-to-0 change on `strobe_fall` while the channel's `set_in` bit is 1 starts that channel, with the same latency as R3.
- R5: A 0-to-1 change on `common_arm` starts every channel whose `set_in` bit is 1 at that time.
- R6: While `common_arm` is held at 1, a 0-to-1 change on a channel's own `set_in` bit starts that channel only.
- R7: A strobe or arm edge does not start a channel whose `set_in` bit is 0.
- R8: While `in_disable` is 1, no strobe, arm or set edge starts any channel.
- R9: A start event on a channel that is already high is ignored. The pulse is neither restarted nor lengthened.
- R10: Raising `inhibit` drives every output low by the third rising clock edge after the change. The next start after `inhibit` is released gives a full `PULSE_LEN` pulse.
- R11: Start events that occur while `inhibit` is 1 are ignored.
- R12: The channels time independently. A channel may start while others are partway through their pulses, and each ends on its own schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_in | input | NUM_CH | Per-channel set lines |
| strobe_rise | input | 1 | Strobe that acts on its rising edge |
| strobe_fall | input | 1 | Strobe that acts on its falling edge |
| common_arm | input | 1 | Common arm line: its rising edge starts set channels; held high, it lets set edges start channels |
| in_disable | input | 1 | Blocks all new start events while 1 |
| inhibit | input | 1 | Aborts running pulses and forces outputs low while 1 |
| pulse_out | output | NUM_CH | Per-channel timed pulse outputs |

## Verification
A wrong internal state shows up mainly in the width of the pulse at the port. If a feedback sequence is seeded wrongly, or the terminal state is decoded from the wrong step, the falling edge moves by one or more cycles. That error is visible at the end of the very first pulse, 100 cycles after the start. A fault in the edge detection or in the coincidence gating shows three cycles after the stimulus, either as a start that is missing or as an extra one. If inhibit fails to restore the seed, the first pulse after release comes out with the wrong width.

// File: rtl/pt_pkg.sv
// Shared constants and helpers for the quad pulse timer.
// Assumes: the feedback polynomial x^7 + x^6 + 1 is primitive, so the
// sequence runs for 127 states before repeating, which is more than any
// PULSE_LEN the block is built with.
package pt_pkg;
    localparam int              LFSR_W    = 7;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 7'b1100000;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 7'h01;

    // One step of the Fibonacci shift-register sequence.
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], ^(s & LFSR_TAPS)};
    endfunction

    // Sequence value reached n steps after the seed.
    function automatic logic [LFSR_W-1:0] lfsr_after(input int n);
        logic [LFSR_W-1:0] s;
        s = LFSR_SEED;
        for (int k = 0; k < n; k++) s = lfsr_step(s);
        return s;
    endfunction
endpackage

// File: rtl/pt_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous control inputs.
// Assumes: each bit is a slow level, so the bits need no coherence with
// one another; every stage resets to 0.
module pt_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the bundle through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pt_trigger.sv
// Start-event detection for all channels.
// Edges are found by comparing each synchronized input with its value one
// cycle earlier. A channel starts when its set line and a common edge occur
// together, or when its own set line rises while the arm line is held high.
// Disable and inhibit block all starts.
// Assumes: all inputs are already synchronous to clk.
module pt_trigger #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_s,
    input  logic              stb_r_s,
    input  logic              stb_f_s,
    input  logic              arm_s,
    input  logic              dis_s,
    input  logic              inh_s,
    output logic [NUM_CH-1:0] trig
);
    logic [NUM_CH-1:0] set_d;
    logic              stb_r_d, stb_f_d, arm_d;
    logic              common_edge;
    logic              gate_ok;

    // Keep the previous synchronized values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_d   <= '0;
            stb_r_d <= 1'b0;
            stb_f_d <= 1'b0;
            arm_d   <= 1'b0;
        end else begin
            set_d   <= set_s;
            stb_r_d <= stb_r_s;
            stb_f_d <= stb_f_s;
            arm_d   <= arm_s;
        end
    end

    // An edge shared by all channels: rising strobe, falling strobe or rising arm.
    always_comb begin
        common_edge = (stb_r_s & ~stb_r_d) | (~stb_f_s & stb_f_d) | (arm_s & ~arm_d);
        gate_ok     = ~dis_s & ~inh_s;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // Start condition for one channel, in either of the two modes.
        always_comb begin
            trig[g] = gate_ok & ((set_s[g] & common_edge) |
                                 (set_s[g] & ~set_d[g] & arm_s));
        end
    end
endmodule

// File: rtl/pt_channel.sv
// One timer channel. A start sets the output and times PULSE_LEN periods with
// a feedback sequence. The terminal value is decoded PULSE_LEN-1 steps after
// the seed. Abort clears the output and reloads the seed.
// Assumes: 2**LFSR_W - 1 >= PULSE_LEN, so the terminal value is unique.
module pt_channel
    import pt_pkg::*;
#(
    parameter int PULSE_LEN = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic active
);
    localparam logic [LFSR_W-1:0] TERM = lfsr_after(PULSE_LEN - 1);

    logic [LFSR_W-1:0] state;

    // Run the delay sequence; a start while active has no effect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            state  <= LFSR_SEED;
        end else if (abort) begin
            active <= 1'b0;
            state  <= LFSR_SEED;
        end else if (active) begin
            if (state == TERM) begin
                active <= 1'b0;
                state  <= LFSR_SEED;
            end else begin
                state  <= lfsr_step(state);
            end
        end else if (start) begin
            active <= 1'b1;
            state  <= LFSR_SEED;
        end
    end
endmodule

// File: rtl/quad_pulse_timer.sv
// Top level: a quad one-shot timer with shared strobes, arm, disable and inhibit.
// The inputs are synchronized, start events are detected, and each channel
// times its own fixed-width pulse.
// Assumes: the inputs are asynchronous levels that each hold for at least two
// clock periods.
module quad_pulse_timer #(
    parameter int NUM_CH      = 4,
    parameter int PULSE_LEN   = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_in,
    input  logic              strobe_rise,
    input  logic              strobe_fall,
    input  logic              common_arm,
    input  logic              in_disable,
    input  logic              inhibit,
    output logic [NUM_CH-1:0] pulse_out
);
    localparam int SW = NUM_CH + 5;

    logic [SW-1:0]     raw_bus, sync_bus;
    logic [NUM_CH-1:0] set_s, trig;
    logic              stb_r_s, stb_f_s, arm_s, dis_s, inh_s;

    // Gather the control inputs into one bundle for synchronizing.
    always_comb begin
        raw_bus = {inhibit, in_disable, common_arm, strobe_fall, strobe_rise, set_in};
        {inh_s, dis_s, arm_s, stb_f_s, stb_r_s, set_s} = sync_bus;
    end

    pt_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
    );

    pt_trigger #(.NUM_CH(NUM_CH)) u_trig (
        .clk(clk), .rst_n(rst_n), .set_s(set_s), .stb_r_s(stb_r_s),
        .stb_f_s(stb_f_s), .arm_s(arm_s), .dis_s(dis_s), .inh_s(inh_s),
        .trig(trig)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pt_channel #(.PULSE_LEN(PULSE_LEN)) u_ch (
            .clk(clk), .rst_n(rst_n), .start(trig[g]), .abort(inh_s),
            .active(pulse_out[g])
        );
    end
endmodule

// File: rtl/pt_checker.sv
// Property checker for quad_pulse_timer. It is bound to the top and watches
// the outputs, the synchronized controls and the start signals.
module pt_checker #(
    parameter int NUM_CH    = 4,
    parameter int PULSE_LEN = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] pulse_out,
    input logic [NUM_CH-1:0] trig,
    input logic              inh_s,
    input logic              dis_s
);
    localparam int CW = $clog2(PULSE_LEN + 2);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        logic [CW-1:0] hi_cnt;

        // Count how many samples the output has been high without a break.
        always_ff @(posedge clk) begin
            if (!rst_n)            hi_cnt <= '0;
            else if (pulse_out[g]) hi_cnt <= hi_cnt + 1'b1;
            else                   hi_cnt <= '0;
        end

        // R2
        width_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hi_cnt <= CW'(PULSE_LEN));

        // R2
        full_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(pulse_out[g]) && !$past(inh_s)) |-> hi_cnt == CW'(PULSE_LEN));

        // R3
        start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pulse_out[g]) |-> $past(trig[g]));
    end

    // R10
    inhibit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inh_s |=> pulse_out == '0);

    // R8
    disable_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_s |-> trig == '0);

    // R11
    inhibit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inh_s |-> trig == '0);
endmodule

bind quad_pulse_timer pt_checker #(.NUM_CH(NUM_CH), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .pulse_out(pulse_out), .trig(trig),
    .inh_s(inh_s), .dis_s(dis_s)
);

// File: tb/quad_pulse_timer_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue the expected start and end cycles for
// each channel, and a monitor compares every output edge it sees against them.
module quad_pulse_timer_test;
    localparam int NCH  = 4;
    localparam int PLEN = 100;
    localparam int LAT  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] set_in = '0;
    logic           stb_r = 1'b0, stb_f = 1'b1, arm = 1'b0, dis = 1'b0, inh = 1'b0;
    logic [NCH-1:0] pulse_out;
    logic [NCH-1:0] prev_out = '0;

    int    cyc = 0, n_chk = 0, n_bad = 0;
    bit    done = 1'b0;
    int    exp_rise [NCH][$];
    int    exp_fall [NCH][$];
    string exp_tag  [NCH][$];
    int    pend_fall [NCH];
    string pend_tag  [NCH];
    int    r_val;

    quad_pulse_timer #(.NUM_CH(NCH), .PULSE_LEN(PLEN)) uut (
        .clk(clk), .rst_n(rst_n), .set_in(set_in), .strobe_rise(stb_r),
        .strobe_fall(stb_f), .common_arm(arm), .in_disable(dis),
        .inhibit(inh), .pulse_out(pulse_out)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic expect_pulse(input int ch, input int rise, input int fall, input string tag);
        exp_rise[ch].push_back(rise);
        exp_fall[ch].push_back(fall);
        exp_tag[ch].push_back(tag);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare every output edge with the front of its channel queue.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (pulse_out[ch] && !prev_out[ch]) begin
                    if (exp_rise[ch].size() == 0) begin
                        check(1'b0, "R7 R8 R9 R11 unexpected start", cyc, -1);
                        pend_fall[ch] = -1;
                        pend_tag[ch]  = "R7 R8 R9 R11 unexpected pulse";
                    end else begin
                        r_val = exp_rise[ch].pop_front();
                        pend_fall[ch] = exp_fall[ch].pop_front();
                        pend_tag[ch]  = exp_tag[ch].pop_front();
                        check(r_val == cyc, {pend_tag[ch], " start"}, cyc, r_val);
                    end
                end
                if (!pulse_out[ch] && prev_out[ch])
                    check(pend_fall[ch] == cyc, {pend_tag[ch], " end"}, cyc, pend_fall[ch]);
            end
        end
        prev_out <= pulse_out;
    end

    initial begin
        int t, t2;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        check(pulse_out == '0, "R1 reset outputs", int'(pulse_out), 0);

        // Positive strobe on channel 0 only, then a retrigger mid-pulse.
        set_in = 4'b0001;
        tick(3);
        t = cyc;
        expect_pulse(0, t + LAT, t + LAT + PLEN, "R2 R3 R7");
        stb_r = 1'b1; tick(2); stb_r = 1'b0;
        tick(45);
        stb_r = 1'b1; tick(2); stb_r = 1'b0;   // R9: ignored while running
        tick(70);
        check(pulse_out == '0, "R2 R9 idle after pulse", int'(pulse_out), 0);

        // Negative strobe on channels 1 and 2.
        set_in = 4'b0110;
        tick(2);
        t = cyc;
        expect_pulse(1, t + LAT, t + LAT + PLEN, "R4");
        expect_pulse(2, t + LAT, t + LAT + PLEN, "R4");
        stb_f = 1'b0; tick(3); stb_f = 1'b1;
        tick(110);

        // Input disable blocks every kind of edge.
        set_in = 4'b1111; dis = 1'b1;
        tick(3);
        stb_r = 1'b1; arm = 1'b1; stb_f = 1'b0;
        tick(3);
        stb_r = 1'b0; arm = 1'b0; stb_f = 1'b1;
        tick(10);
        check(pulse_out == '0, "R8 disable blocks starts", int'(pulse_out), 0);
        dis = 1'b0; set_in = '0;
        tick(3);

        // Arm edge starts channels 1 and 3; own-set start on channel 0 while armed.
        set_in = 4'b1010;
        tick(3);
        t = cyc;
        expect_pulse(1, t + LAT, t + LAT + PLEN, "R5");
        expect_pulse(3, t + LAT, t + LAT + PLEN, "R5");
        arm = 1'b1;
        tick(30);
        t2 = cyc;
        expect_pulse(0, t2 + LAT, t2 + LAT + PLEN, "R6 R12");
        set_in[0] = 1'b1;
        tick(20);
        check(pulse_out == 4'b1011, "R12 overlapping channels", int'(pulse_out), 11);
        tick(100);
        arm = 1'b0; set_in = '0;
        tick(3);

        // Inhibit aborts all four pulses; starts during inhibit are ignored.
        set_in = 4'b1111;
        tick(3);
        t = cyc;
        for (int ch = 0; ch < NCH; ch++)
            expect_pulse(ch, t + LAT, t + 40 + LAT, "R10 abort");
        stb_r = 1'b1; tick(2); stb_r = 1'b0;
        tick(38);
        inh = 1'b1;
        tick(5);
        check(pulse_out == '0, "R10 inhibit forces low", int'(pulse_out), 0);
        stb_r = 1'b1; tick(2); stb_r = 1'b0;   // R11: ignored
        tick(10);
        check(pulse_out == '0, "R11 start during inhibit", int'(pulse_out), 0);
        inh = 1'b0;
        tick(5);
        t = cyc;
        for (int ch = 0; ch < NCH; ch++)
            expect_pulse(ch, t + LAT, t + LAT + PLEN, "R10 full pulse after release");
        stb_r = 1'b1; tick(2); stb_r = 1'b0;
        tick(110);

        for (int ch = 0; ch < NCH; ch++)
            check(exp_rise[ch].size() == 0, "R2 all expected pulses seen",
                  exp_rise[ch].size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule